// File: doc/BRIEF.md
# Memory Tag Range Checker

This block decides whether a memory access may proceed under memory tagging. Every 16-byte granule of memory carries a 4-bit allocation tag, and the access pointer carries its own 4-bit tag. Given the first byte address of an access, its length minus one and the pointer tag, the checker walks every granule the access covers. It reads each granule's allocation tag from a tag store that packs two tags into each byte, and stops at the first granule whose tag differs from the pointer tag. When it finishes it pulses `done` and reports a pass, or a fail with the address of the faulting granule.

Some accesses skip the walk and pass at once. This happens when top-byte tagging is switched off for the address half, or when the match-all shortcut applies. An access that crosses a page boundary reads the second page's tags as a separate segment, and each page can be marked as untagged. A block mode checks a whole aligned 64-byte block, as a cache-block zeroing operation needs. Tag reads go to a byte-wide store with one cycle of read latency.

Top module: `memtag_range_check`

## Requirements
- R1: Granule address G has its tag in tag-store byte G>>5. Bit 4 of G selects the nibble: bits [3:0] hold the tag when bit 4 is 0, and bits [7:4] hold it when bit 4 is 1.
- R2: A normal check covers the granules from align16(addr) to align16(addr+size_m1), inclusive and in ascending order. Each granule is compared once. The walk stops at the first mismatch with `pass`=0; if every granule matches, `pass`=1.
- R3: If the mismatch is at granule index 0 of a normal check, `fault_addr` is the original start address. At any later index n it is align16(addr)+16·n.
- R4: Address bit 55 selects an address half. If `tbi_en` is 0 for that half, `done`=1 and `pass`=1 appear in the cycle after the request, and no tag read is issued.
- R5: Suppose `tcma_en` is 1 for the selected half. If the pointer tag is 0x0 in the low half, or 0xF in the high half, the access passes one cycle after the request with no tag read. Any other tag value is checked normally.
- R6: Granules on the start page use `page_tagged[0]`, and granules on the following page use `page_tagged[1]`. A granule on an untagged page passes without a read. The following page begins at the low nibble of its own tag byte.
- R7: With `req_blk`=1, the checked range is the aligned 64-byte block that contains addr, and `size_m1` is ignored. The fault address is block_base+16·n, and this holds for n=0 as well.
- R8: Each tagged granule costs one read and two cycles, and each untagged granule costs one cycle. `done` is a single-cycle pulse. A request that arrives while `busy`=1 is ignored.
- R9: During and after reset, `busy`, `done`, `pass` and `tm_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a check (taken only when idle) |
| req_addr | input | AW | First byte address of the access |
| req_size_m1 | input | SW | Access length minus one |
| req_ptag | input | 4 | Pointer tag |
| req_blk | input | 1 | Check the whole aligned 64-byte block |
| tbi_en | input | 2 | Top-byte tagging enable, per address half |
| tcma_en | input | 2 | Match-all shortcut enable, per address half |
| page_tagged | input | 2 | Tagged flag for the start page [0] and the next page [1] |
| busy | output | 1 | Check in progress |
| tm_rd_en | output | 1 | Tag-store read strobe |
| tm_rd_addr | output | AW-5 | Tag-store byte address |
| tm_rd_data | input | 8 | Tag-store read data, one cycle after the strobe |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | Result: 1 means the access is allowed |
| fault_addr | output | AW | Address of the first failing granule (0 on pass) |

## Verification
Two events can fall in the same cycle: a mismatch found on the final granule, and the end of the range. A two-granule access whose second granule holds the bad tag provokes this, and the mismatch must win with a fault at that granule's base. Page crossing can coincide with the odd-nibble position. An access that starts on the last, odd granule of a page must read the high nibble there and then the low nibble of the next page's first byte; this is judged by the fault address and by the read count. A second request pulsed in the middle of a walk checks that the request and the walk do not interact.

// File: rtl/memtag_range_check.sv
module memtag_range_check #(
  parameter int AW        = 56,
  parameter int SW        = 8,
  parameter int PAGE_LOG2 = 12,
  parameter int BLK_LOG2  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size_m1,
  input  logic [3:0]    req_ptag,
  input  logic          req_blk,
  input  logic [1:0]    tbi_en,
  input  logic [1:0]    tcma_en,
  input  logic [1:0]    page_tagged,
  output logic          busy,
  output logic          tm_rd_en,
  output logic [AW-6:0] tm_rd_addr,
  input  logic [7:0]    tm_rd_data,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fault_addr
);
  localparam int GW = AW - 4;
  localparam int PW = AW - PAGE_LOG2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CMP} st_t;
  st_t st;

  logic [GW-1:0] cur_g, last_q;
  logic [AW-1:0] orig_q;
  logic [PW-1:0] pg_q;
  logic [3:0]    ptag_q;
  logic [1:0]    tagged_q;
  logic          blk_q, first_q;

  wire          half     = req_addr[AW-1];
  wire          tbi_off  = !tbi_en[half];
  wire          tcma_hit = tcma_en[half] && (req_ptag == {4{half}});
  wire [AW-1:0] end_addr = req_addr + {{(AW-SW){1'b0}}, req_size_m1};
  wire [GW-1:0] first_g  = req_blk ? {req_addr[AW-1:BLK_LOG2], {(BLK_LOG2-4){1'b0}}}
                                   : req_addr[AW-1:4];
  wire [GW-1:0] last_g   = req_blk ? {req_addr[AW-1:BLK_LOG2], {(BLK_LOG2-4){1'b1}}}
                                   : end_addr[AW-1:4];

  wire          on_next    = cur_g[GW-1:PAGE_LOG2-4] != pg_q;
  wire          tagged_now = on_next ? tagged_q[1] : tagged_q[0];
  wire          is_last    = cur_g == last_q;
  wire [3:0]    nib        = cur_g[0] ? tm_rd_data[7:4] : tm_rd_data[3:0];
  wire [AW-1:0] fault_pos  = (first_q && !blk_q) ? orig_q : {cur_g, 4'b0000};

  assign busy       = st != S_IDLE;
  assign tm_rd_en   = (st == S_RD) && tagged_now;
  assign tm_rd_addr = cur_g[GW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      done       <= 1'b0;
      pass       <= 1'b0;
      fault_addr <= '0;
      cur_g      <= '0;
      last_q     <= '0;
      orig_q     <= '0;
      pg_q       <= '0;
      ptag_q     <= '0;
      tagged_q   <= '0;
      blk_q      <= 1'b0;
      first_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          if (tbi_off || tcma_hit) begin
            done       <= 1'b1;
            pass       <= 1'b1;
            fault_addr <= '0;
          end else begin
            st       <= S_RD;
            cur_g    <= first_g;
            last_q   <= last_g;
            orig_q   <= req_addr;
            pg_q     <= req_addr[AW-1:PAGE_LOG2];
            ptag_q   <= req_ptag;
            tagged_q <= page_tagged;
            blk_q    <= req_blk;
            first_q  <= 1'b1;
          end
        end
        S_RD: begin
          if (tagged_now) begin
            st <= S_CMP;
          end else if (is_last) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            pass       <= 1'b1;
            fault_addr <= '0;
          end else begin
            cur_g   <= cur_g + 1'b1;
            first_q <= 1'b0;
          end
        end
        S_CMP: begin
          if (nib != ptag_q) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            pass       <= 1'b0;
            fault_addr <= fault_pos;
          end else if (is_last) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            pass       <= 1'b1;
            fault_addr <= '0;
          end else begin
            st      <= S_RD;
            cur_g   <= cur_g + 1'b1;
            first_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R8
  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tm_rd_en |=> !tm_rd_en);                                          // R8
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tm_rd_en);                                             // R8
  AST_FAIL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> $past(tm_rd_en, 2));                          // R2
  AST_FAULT_IN_READ_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> fault_addr[AW-1:5] == $past(tm_rd_addr, 2));  // R1
  AST_TBI_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && tbi_off) |=> (done && pass && !tm_rd_en)); // R4
  AST_TCMA_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && tcma_hit) |=> (done && pass && !busy));    // R5
endmodule

// File: tb/memtag_range_check_test.sv
module memtag_range_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [55:0] req_addr = '0;
  logic [7:0]  req_size_m1 = '0;
  logic [3:0]  req_ptag = '0;
  logic        req_blk = 1'b0;
  logic [1:0]  tbi_en = 2'b11;
  logic [1:0]  tcma_en = 2'b00;
  logic [1:0]  page_tagged = 2'b11;
  logic        busy, tm_rd_en, done, pass;
  logic [50:0] tm_rd_addr;
  logic [7:0]  tm_rd_data;
  logic [55:0] fault_addr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  memtag_range_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size_m1(req_size_m1), .req_ptag(req_ptag), .req_blk(req_blk),
    .tbi_en(tbi_en), .tcma_en(tcma_en), .page_tagged(page_tagged),
    .busy(busy), .tm_rd_en(tm_rd_en), .tm_rd_addr(tm_rd_addr),
    .tm_rd_data(tm_rd_data), .done(done), .pass(pass), .fault_addr(fault_addr)
  );

  logic [7:0] tmem [256];
  always_ff @(posedge clk) if (tm_rd_en) tm_rd_data <= tmem[tm_rd_addr[7:0]];

  typedef struct packed {
    logic [55:0] addr;
    logic [7:0]  sz;
    logic [3:0]  tag;
    logic        blk;
    logic [1:0]  tbi;
    logic [1:0]  tcma;
    logic [1:0]  pgt;
    logic        ep;
    logic [55:0] ef;
    logic [7:0]  er;
    logic [7:0]  ec;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{56'h100, 8'd15,   4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b1, 56'h0,   8'd1, 8'd3},
    '{56'h108, 8'h2F,   4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b0, 56'h130, 8'd4, 8'd9},
    '{56'h135, 8'd3,    4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b0, 56'h135, 8'd1, 8'd3},
    '{56'h13C, 8'd3,    4'hA, 1'b0, 2'b11, 2'b00, 2'b11, 1'b1, 56'h0,   8'd1, 8'd3},
    '{56'hFF8, 8'd15,   4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b0, 56'h1000,8'd2, 8'd5},
    '{56'hFF8, 8'd15,   4'h5, 1'b0, 2'b11, 2'b00, 2'b01, 1'b1, 56'h0,   8'd1, 8'd4},
    '{56'hFF8, 8'd15,   4'hC, 1'b0, 2'b11, 2'b00, 2'b10, 1'b1, 56'h0,   8'd1, 8'd4},
    '{56'h135, 8'd3,    4'h5, 1'b0, 2'b10, 2'b00, 2'b11, 1'b1, 56'h0,   8'd0, 8'd1},
    '{56'h80000000000135, 8'd3, 4'h5, 1'b0, 2'b01, 2'b00, 2'b11, 1'b1, 56'h0, 8'd0, 8'd1},
    '{56'h80000000000135, 8'd3, 4'h5, 1'b0, 2'b10, 2'b00, 2'b11, 1'b0, 56'h80000000000135, 8'd1, 8'd3},
    '{56'h135, 8'd3,    4'h0, 1'b0, 2'b11, 2'b01, 2'b11, 1'b1, 56'h0,   8'd0, 8'd1},
    '{56'h135, 8'd3,    4'hF, 1'b0, 2'b11, 2'b01, 2'b11, 1'b0, 56'h135, 8'd1, 8'd3},
    '{56'h80000000000135, 8'd3, 4'hF, 1'b0, 2'b11, 2'b10, 2'b11, 1'b1, 56'h0, 8'd0, 8'd1},
    '{56'h128, 8'd0,    4'h5, 1'b1, 2'b11, 2'b00, 2'b11, 1'b0, 56'h130, 8'd4, 8'd9},
    '{56'h13C, 8'd0,    4'hA, 1'b1, 2'b11, 2'b00, 2'b11, 1'b0, 56'h100, 8'd1, 8'd3},
    '{56'h44,  8'd200,  4'h5, 1'b1, 2'b11, 2'b00, 2'b11, 1'b1, 56'h0,   8'd4, 8'd9},
    '{56'h12F, 8'd0,    4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b1, 56'h0,   8'd1, 8'd3},
    '{56'h12F, 8'd1,    4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b0, 56'h130, 8'd2, 8'd5},
    '{56'hFF0, 8'd31,   4'h5, 1'b0, 2'b11, 2'b00, 2'b11, 1'b0, 56'h1000,8'd2, 8'd5}
  };
  localparam string RQ [NV] = '{
    "R2", "R2", "R3", "R1", "R6", "R6", "R6", "R4", "R4", "R4",
    "R5", "R5", "R5", "R7", "R7", "R7", "R2", "R3", "R6"
  };

  task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input string rq, input bit mid_req);
    int cyc = 0;
    int rds = 0;
    bit seen = 0;
    @(negedge clk);
    req_addr = v.addr; req_size_m1 = v.sz; req_ptag = v.tag; req_blk = v.blk;
    tbi_en = v.tbi; tcma_en = v.tcma; page_tagged = v.pgt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 64; k++) begin
      cyc++;
      if (tm_rd_en) rds++;
      if (mid_req && cyc == 2) begin
        req_addr = 56'h0; tbi_en = 2'b00; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(rq, "done seen", seen, 1);
    check(rq, "pass", pass, v.ep);
    check(rq, "fault_addr", fault_addr, v.ef);
    check(rq, "read count", rds, v.er);
    check("R8", "latency", cyc, v.ec);
    @(negedge clk);
    check("R8", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h55;
    tmem[8'h09] = 8'hA5;
    tmem[8'h80] = 8'h5C;
    repeat (3) @(negedge clk);
    check("R9", "busy in reset", busy, 0);
    check("R9", "done in reset", done, 0);
    check("R9", "pass in reset", pass, 0);
    check("R9", "rd_en in reset", tm_rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "busy after reset", busy, 0);
    for (int i = 0; i < NV; i++) run(VECS[i], RQ[i], 1'b0);
    run(VECS[1], "R8", 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule